// File: doc/BRIEF.md
# Keystream Configuration Decryptor

This block loads a volatile FPGA from an encrypted image held in a byte-wide parallel EPROM. After a start pulse it walks the EPROM from address zero upward. It captures each byte and shifts it out one bit at a time, most significant bit first. Before a bit leaves, it is XORed with one bit of a keystream, so the FPGA receives clear configuration bits together with a configuration clock. The keystream generator is a 20-stage linear feedback shift register with the feedback XOR placed between stages. It starts from a built-in nonzero constant that models bits set at power-on. No pin can load the keystream state from outside.

The image length in bits is a parameter. Once that many bits have been clocked out, the block stops the configuration clock, drops `busy` and raises `done`. A later start pulse repeats the load from the beginning with the same keystream. Because the keystream period is 2^20 - 1 steps, no keystream bit repeats within a load of up to about a million bits.

Top module: `cfg_decrypt_loader`

## Requirements
- R1: After reset, and before the first start, `busy`, `done`, `cfg_clk` and `rom_addr` are all 0.
- R2: Each delivered bit on `cfg_data` equals the encrypted bit XOR the keystream bit. The keystream bit is bit 0 of the 20-bit generator state. After each delivered bit the state shifts right by one. When the bit that left was 1, the new state is also XORed with a mask that has bits 19 and 2 set; this realises x^20 + x^3 + 1. The first bit of a load uses the seed state.
- R3: Byte k of the image is read from EPROM address k, and its bits go out most significant first. The next address is driven from the edge on which a byte is captured. So while bit j of the image is on the pins, `rom_addr` is j/8 + 1, except after the rising `cfg_clk` of the eighth bit of a byte, when it is already j/8 + 2. `rom_data` must be valid one clock after `rom_addr` changes.
- R4: Each bit is set on `cfg_data` with `cfg_clk` low, then `cfg_clk` is high for exactly one clock. `cfg_data` does not change while `cfg_clk` is high.
- R5: After exactly IMAGE_BITS rising edges of `cfg_clk`, `done` rises and `busy` falls one clock later. No further `cfg_clk` pulses follow, even when IMAGE_BITS is not a multiple of 8.
- R6: A start pulse while idle reloads the seed and sets the address back to 0, so a repeated load delivers the same clear bit sequence.
- R7: A start pulse while `busy` is high has no effect: the running load continues with an unchanged address sequence and keystream.
- R8: If the SEED parameter is 0, the generator starts from the value 1 instead, and its state is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (used only while idle) |
| rom_addr | output | ADDR_W | EPROM byte address |
| rom_data | input | 8 | EPROM read data (encrypted byte) |
| cfg_clk | output | 1 | Configuration clock to the FPGA |
| cfg_data | output | 1 | Decrypted serial configuration bit |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed; held until the next start |

## Verification
Two functions can fall in the same cycle. The first is a byte capture together with the address step on the edge that also raises `cfg_clk` for the eighth bit of a byte. The second is a start pulse that arrives while a load is running, which has to be ignored. The bench provokes the first on every byte boundary of a full 61-bit image. At each such boundary it compares `rom_addr` and the delivered bit with values computed from the byte-address rule and an independent model of the keystream. It provokes the second by pulsing `start` in the middle of the load. It judges the pulse ignored only if every later bit, the address sequence and the final bit count still match those of an uninterrupted load.

// File: rtl/cfg_decrypt_loader.sv
module cfg_decrypt_loader #(
  parameter int          ADDR_W     = 20,
  parameter int          IMAGE_BITS = 1040096,
  parameter logic [19:0] SEED       = 20'h6B3D9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              cfg_clk,
  output logic              cfg_data,
  output logic              busy,
  output logic              done
);
  localparam int          CNT_W    = $clog2(IMAGE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IMAGE_BITS);
  localparam logic [19:0] TAP_MASK = 20'h80004;
  localparam logic [19:0] SEED_EFF = (SEED == 20'h0) ? 20'h00001 : SEED;

  logic              busy_q, done_q, fill_q, phase_q, cclk_q, cdat_q;
  logic [2:0]        bitidx_q;
  logic [7:0]        sh_q;
  logic [19:0]       lfsr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  wire [19:0] lfsr_nx = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAP_MASK : 20'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fill_q   <= 1'b0;
      phase_q  <= 1'b0;
      cclk_q   <= 1'b0;
      cdat_q   <= 1'b0;
      bitidx_q <= '0;
      sh_q     <= '0;
      lfsr_q   <= SEED_EFF;
      cnt_q    <= '0;
      addr_q   <= '0;
    end else if (!busy_q) begin
      cclk_q <= 1'b0;
      if (start) begin
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        fill_q   <= 1'b1;
        phase_q  <= 1'b0;
        bitidx_q <= '0;
        lfsr_q   <= SEED_EFF;
        cnt_q    <= '0;
        addr_q   <= '0;
      end
    end else if (fill_q) begin
      sh_q    <= rom_data;
      addr_q  <= addr_q + 1'b1;
      fill_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (!phase_q) begin
      cclk_q <= 1'b0;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cdat_q  <= sh_q[7] ^ lfsr_q[0];
        phase_q <= 1'b1;
      end
    end else begin
      cclk_q   <= 1'b1;
      phase_q  <= 1'b0;
      lfsr_q   <= lfsr_nx;
      cnt_q    <= cnt_q + 1'b1;
      bitidx_q <= bitidx_q + 1'b1;
      if (bitidx_q == 3'd7) begin
        sh_q   <= rom_data;
        addr_q <= addr_q + 1'b1;
      end else begin
        sh_q <= {sh_q[6:0], 1'b0};
      end
    end
  end

  assign rom_addr = addr_q;
  assign cfg_clk  = cclk_q;
  assign cfg_data = cdat_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

module cfg_decrypt_loader_chk #(
  parameter int          ADDR_W = 20,
  parameter logic [19:0] SEED   = 20'h6B3D9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cfg_clk,
  input logic              cfg_data,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [19:0]       lfsr
);
  localparam logic [19:0] SEED_EFF = (SEED == 20'h0) ? 20'h00001 : SEED;

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_data));

  // R4
  clk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |=> !cfg_clk);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cfg_clk));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rom_addr == '0 && lfsr == SEED_EFF));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> rom_addr != '0);

  // R8
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 20'h0);
endmodule

bind cfg_decrypt_loader cfg_decrypt_loader_chk #(.ADDR_W(ADDR_W), .SEED(SEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_clk(cfg_clk), .cfg_data(cfg_data), .rom_addr(rom_addr), .lfsr(lfsr_q)
);

// File: tb/cfg_decrypt_loader_bench.sv
`timescale 1ns/1ps
module cfg_decrypt_loader_bench;
  localparam int          AW    = 8;
  localparam int          NBITS = 61;
  localparam logic [19:0] SEEDA = 20'h5A3C1;
  localparam int          NBB   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic [AW-1:0] addr_a, addr_b;
  logic [7:0] data_a, data_b;
  logic cclk_a, cdat_a, busy_a, done_a;
  logic cclk_b, cdat_b, busy_b, done_b;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_f(input logic [AW-1:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  function automatic logic [19:0] step(input logic [19:0] s);
    return (s >> 1) ^ (s[0] ? 20'h80004 : 20'h0);
  endfunction

  function automatic logic enc_bit(input int j);
    logic [7:0] b;
    b = rom_f(AW'(j / 8));
    return b[7 - (j % 8)];
  endfunction

  assign data_a = rom_f(addr_a);
  assign data_b = rom_f(addr_b);

  cfg_decrypt_loader #(.ADDR_W(AW), .IMAGE_BITS(NBITS), .SEED(SEEDA)) u_cfg_decrypt_loader (
    .clk(clk), .rst_n(rst_n), .start(start_a), .rom_addr(addr_a), .rom_data(data_a),
    .cfg_clk(cclk_a), .cfg_data(cdat_a), .busy(busy_a), .done(done_a));

  cfg_decrypt_loader #(.ADDR_W(AW), .IMAGE_BITS(NBB), .SEED(20'h0)) u_zero_seed (
    .clk(clk), .rst_n(rst_n), .start(start_b), .rom_addr(addr_b), .rom_data(data_b),
    .cfg_clk(cclk_b), .cfg_data(cdat_b), .busy(busy_b), .done(done_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_a(input bit poke_start);
    logic [19:0] ks = SEEDA;
    int   nb = 0;
    logic prev = 1'b0;
    logic held = 1'b0;
    bit   poked = 1'b0;
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    check(busy_a == 1'b1, "R6 busy after start", busy_a, 1);
    while (!done_a && nb <= NBITS + 2) begin
      @(negedge clk);
      start_a = 1'b0;
      if (poke_start && nb == 20 && !poked) begin
        start_a = 1'b1;
        poked = 1'b1;
      end
      if (cclk_a && !prev) begin
        check(cdat_a == (enc_bit(nb) ^ ks[0]), "R2 clear bit", cdat_a, enc_bit(nb) ^ ks[0]);
        check(cdat_a == held, "R4 data stable under cfg_clk", cdat_a, held);
        check(int'(addr_a) == nb / 8 + 1 + ((nb % 8 == 7) ? 1 : 0), "R3 address",
              addr_a, nb / 8 + 1 + ((nb % 8 == 7) ? 1 : 0));
        ks = step(ks);
        nb++;
      end
      if (!cclk_a) held = cdat_a;
      prev = cclk_a;
    end
    start_a = 1'b0;
    check(nb == NBITS, poke_start ? "R7 bit count with start while busy" : "R5 bit count",
          nb, NBITS);
    check(done_a && !busy_a, "R5 done and idle", {done_a, busy_a}, 2);
    repeat (10) begin
      @(negedge clk);
      check(!cclk_a && done_a, "R5 no clock after done", cclk_a, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_a && !done_a && !cclk_a && addr_a == '0, "R1 reset state",
          {busy_a, done_a, cclk_a}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_a && !done_a && !cclk_a && addr_a == '0, "R1 idle before start",
          {busy_a, done_a, cclk_a}, 0);
    run_a(1'b0);
    run_a(1'b1);
    run_a(1'b0);
    begin
      logic [19:0] ks = 20'h00001;
      int   nb = 0;
      logic prev = 1'b0;
      @(negedge clk) start_b = 1'b1;
      @(negedge clk) start_b = 1'b0;
      while (!done_b && nb <= NBB + 2) begin
        @(negedge clk);
        if (cclk_b && !prev) begin
          check(cdat_b == (enc_bit(nb) ^ ks[0]), "R8 zero seed keystream",
                cdat_b, enc_bit(nb) ^ ks[0]);
          ks = step(ks);
          nb++;
        end
        prev = cclk_b;
      end
      check(nb == NBB, "R8 zero seed bit count", nb, NBB);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule